// File: doc/BRIEF.md
# Audio DAC Control Register Bank

This block holds the control registers of a stereo audio codec's DAC side. It sits behind a simple register port: a host writes a 16-bit word to an offset, and the block stores only the bits that each register keeps. Reads return the stored value with some bits fixed high, some bits driven by internal timers, and one register whose flags clear when it is read. Twenty bass-boost coefficient words, two PLL words and a volume word are also held here as plain storage.

Two saturating timers run on a prescaled tick. The first starts again on every volume write and reports when the soft volume ramp would have settled. The second starts when the DAC power-down bit goes from 0 to 1 and reports when power-down has finished. A rate decoder reads the divisor field and the reference-select bit and gives the DAC sample rate in hertz, an invalid-rate flag and a DAC-enable signal. Two event inputs let the datapath set the sticky flags in the third control word.

Top module: `dac_ctl_regs`

## Requirements
- R1: Offset 0 (control 1) keeps written bits under mask 0x0F3F and reads back what it stored; its bits 5:0 are the rate divisor code.
- R2: Divisor codes 0, 9, 18, 27, 36, 45, 54 and 63 divide the reference by 1, 1.5, 2, 3, 4, 5, 6 and 6. The reference is 44100 Hz when bit 13 of offset 6 is 1 and 48000 Hz when it is 0. `rate_hz` gives the result. Any other code sets `rate_bad` to 1 and `rate_hz` to 0.
- R3: `dac_en` is 1 only when bits 15 and 10 of the power word (offset 5) are both 0.
- R4: The power word stores writes under mask 0x9543 and reads back ORed with 0x2AA0.
- R5: A 0-to-1 change of power bit 10 restarts the power-down timer. Read bit 6 of offset 5 is 1 when the stored bit 6 is 1, or when bit 10 is 1 and the timer has run SETTLE_TICKS ticks of TICK_DIV clocks each.
- R6: Offset 2 (volume) stores all 16 bits, and each write restarts the soft-step timer. While soft-step is enabled and power bit 10 is 0, read bits 3 and 2 of offset 4 stay 0 until the timer has expired. In every other case they read 1.
- R7: Offset 4 (control 2) stores writes under mask 0xF7F2.
- R8: Writing bit 14 of offset 29 (control 4) as 1 disables soft-step. Its read value is the inverse of the soft-step enable in bit 14, with all other bits 0.
- R9: Writing offset 6 (control 3) loads bits 15:11 and keeps bits 7:6. Bits 7 and 6 are set by `flag_evt[1]` and `flag_evt[0]`. A read returns the stored value with bit 0 forced to 1. A read with `rd_en` high clears bits 7:6 at the following edge, unless an event sets them in the same cycle.
- R10: Offsets 27 and 28 (PLL words) store writes with bits 1:0 cleared. Offsets 1 and 3 read 0xFF00 and 0x8B00. Offsets 30 and 31 read 0xFFFF, and writes to them change nothing.
- R11: After reset, control 2 is 0x4410, PLL 1 is 0x1004, volume is 0xFFFF, the power word is 0x8540 and soft-step is enabled. Controls 1 and 3 and PLL 2 are 0.
- R12: Offsets 7 to 26 are coefficient words, left channel first. Each channel resets to 0x6BE3, 0x9666, 0x675D, 0x6BE3, 0x9666, 0x675D, 0x7D83, 0x84EE, 0x7D83, 0x84EE, and each word stores all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| rd_en | input | 1 | Read strobe; allows read side effects |
| addr | input | AW | Register offset |
| wdata | input | 16 | Write data |
| flag_evt | input | 2 | Sets control 3 bits 7 and 6 |
| rdata | output | 16 | Read data for `addr` (combinational) |
| rate_hz | output | 17 | Decoded DAC sample rate in Hz |
| rate_bad | output | 1 | Divisor code not in the table |
| dac_en | output | 1 | DAC power enabled |

## Verification
The rate decoder is swept over all 64 divisor codes with both reference settings. This separates the valid codes from their neighbours and checks that the duplicate divide-by-6 code gives the same result. Every masked register is written with all ones and read back, which exposes any bit kept outside its mask. The timed bits are checked just after their timer restarts and again well past expiry, with soft-step on and off and with power bit 10 in both states. The check after expiry shows whether the gating condition or the timer drives the bit. Control 3 is read with and without the strobe, and with an event in the same cycle, to separate a plain read from a clearing read.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    localparam logic [4:0] OFF_CTRL1  = 5'd0;
    localparam logic [4:0] OFF_FIX1   = 5'd1;
    localparam logic [4:0] OFF_VOL    = 5'd2;
    localparam logic [4:0] OFF_FIX3   = 5'd3;
    localparam logic [4:0] OFF_CTRL2  = 5'd4;
    localparam logic [4:0] OFF_PWR    = 5'd5;
    localparam logic [4:0] OFF_CTRL3  = 5'd6;
    localparam logic [4:0] OFF_COEF0  = 5'd7;
    localparam logic [4:0] OFF_PLL1   = 5'd27;
    localparam logic [4:0] OFF_PLL2   = 5'd28;
    localparam logic [4:0] OFF_CTRL4  = 5'd29;

    localparam logic [15:0] MSK_CTRL1 = 16'h0F3F;
    localparam logic [15:0] MSK_CTRL2 = 16'hF7F2;
    localparam logic [15:0] MSK_PWR   = 16'h9543;
    localparam logic [15:0] OR_PWR    = 16'h2AA0;
    localparam logic [15:0] MSK_PLL   = 16'hFFFC;
    localparam logic [15:0] KEEP_C3   = 16'h00C0;
    localparam logic [15:0] LOAD_C3   = 16'hF800;

    localparam int COEF_PER_CH = 10;
    localparam int COEF_CH     = 2;

    typedef struct packed {
        logic [15:0] ctrl1;
        logic [15:0] vol;
        logic [15:0] ctrl2;
        logic [15:0] pwr;
        logic [15:0] ctrl3;
        logic [15:0] pll1;
        logic [15:0] pll2;
        logic        ss_en;
    } regs_t;

    function automatic logic [15:0] coef_reset(int k);
        case (k)
            0, 3:    return 16'h6BE3;
            1, 4:    return 16'h9666;
            2, 5:    return 16'h675D;
            6, 8:    return 16'h7D83;
            default: return 16'h84EE;
        endcase
    endfunction

    // step 0..6 = divide by 1, 1.5, 2, 3, 4, 5, 6
    function automatic logic [16:0] rate_of(logic [2:0] step, logic ref44);
        case (step)
            3'd0:    return ref44 ? 17'd44100 : 17'd48000;
            3'd1:    return ref44 ? 17'd29400 : 17'd32000;
            3'd2:    return ref44 ? 17'd22050 : 17'd24000;
            3'd3:    return ref44 ? 17'd14700 : 17'd16000;
            3'd4:    return ref44 ? 17'd11025 : 17'd12000;
            3'd5:    return ref44 ? 17'd8820  : 17'd9600;
            default: return ref44 ? 17'd7350  : 17'd8000;
        endcase
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int PRESCALE = 16,
    parameter int LIMIT    = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [PW-1:0] PRE_TOP = PW'(PRESCALE - 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(LIMIT);

    logic [PW-1:0] pre_d, pre_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        pre_d = pre_q;
        cnt_d = cnt_q;
        if (restart) begin
            pre_d = '0;
            cnt_d = '0;
        end else if (cnt_q != CNT_TOP) begin
            if (pre_q == PRE_TOP) begin
                pre_d = '0;
                cnt_d = cnt_q + 1'b1;
            end else begin
                pre_d = pre_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            pre_q <= pre_d;
            cnt_q <= cnt_d;
        end
    end

    assign done = (cnt_q == CNT_TOP);
endmodule

// File: rtl/rate_decode.sv
module rate_decode import dacreg_pkg::*; (
    input  logic [5:0]  divisor,
    input  logic        ref44,
    output logic [16:0] rate_hz,
    output logic        rate_bad
);
    logic [2:0] step;
    logic       hit;

    always_comb begin
        hit  = 1'b1;
        step = 3'd0;
        case (divisor)
            6'd0:        step = 3'd0;
            6'd9:        step = 3'd1;
            6'd18:       step = 3'd2;
            6'd27:       step = 3'd3;
            6'd36:       step = 3'd4;
            6'd45:       step = 3'd5;
            6'd54, 6'd63: step = 3'd6;
            default:     hit  = 1'b0;
        endcase
        rate_bad = !hit;
        rate_hz  = hit ? rate_of(step, ref44) : 17'd0;
    end
endmodule

// File: rtl/coef_bank.sv
module coef_bank import dacreg_pkg::*; #(
    parameter int NCH = COEF_CH,
    parameter int PER = COEF_PER_CH,
    parameter int AW  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata
);
    localparam int N = NCH * PER;

    logic [15:0] word_q [N];

    for (genvar g = 0; g < N; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[g] <= coef_reset(g % PER);
            else if (we && idx == AW'(g))
                word_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = 16'hFFFF;
        for (int i = 0; i < N; i++)
            if (idx == AW'(i)) rdata = word_q[i];
    end
endmodule

// File: rtl/dac_ctl_regs.sv
module dac_ctl_regs import dacreg_pkg::*; #(
    parameter int TICK_DIV     = 16,
    parameter int SETTLE_TICKS = 50,
    parameter int AW           = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    input  logic [1:0]    flag_evt,
    output logic [15:0]   rdata,
    output logic [16:0]   rate_hz,
    output logic          rate_bad,
    output logic          dac_en
);
    localparam int NCOEF = COEF_CH * COEF_PER_CH;
    localparam logic [AW-1:0] COEF_LO = AW'(OFF_COEF0);
    localparam logic [AW-1:0] COEF_HI = AW'(OFF_COEF0) + AW'(NCOEF - 1);

    regs_t r_d, r_q;

    logic          vol_start, pd_start, vol_done, pd_done;
    logic          in_coef, ramp_done;
    logic [AW-1:0] coef_idx;
    logic [15:0]   coef_rd;
    logic [1:0]    c3_flags;
    logic          pwr_b10;

    assign in_coef  = (addr >= COEF_LO) && (addr <= COEF_HI);
    assign coef_idx = addr - COEF_LO;

    always_comb begin
        r_d       = r_q;
        vol_start = 1'b0;
        pd_start  = 1'b0;
        if (wr_en) begin
            case (addr)
                AW'(OFF_CTRL1): r_d.ctrl1 = wdata & MSK_CTRL1;
                AW'(OFF_VOL): begin
                    r_d.vol   = wdata;
                    vol_start = 1'b1;
                end
                AW'(OFF_CTRL2): r_d.ctrl2 = wdata & MSK_CTRL2;
                AW'(OFF_PWR): begin
                    r_d.pwr  = wdata & MSK_PWR;
                    pd_start = wdata[10] && !r_q.pwr[10];
                end
                AW'(OFF_CTRL3): r_d.ctrl3 = (r_q.ctrl3 & KEEP_C3) | (wdata & LOAD_C3);
                AW'(OFF_PLL1):  r_d.pll1  = wdata & MSK_PLL;
                AW'(OFF_PLL2):  r_d.pll2  = wdata & MSK_PLL;
                AW'(OFF_CTRL4): r_d.ss_en = !wdata[14];
                default: ;
            endcase
        end
        if (rd_en && addr == AW'(OFF_CTRL3))
            r_d.ctrl3[7:6] = 2'b00;
        if (flag_evt[1]) r_d.ctrl3[7] = 1'b1;
        if (flag_evt[0]) r_d.ctrl3[6] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ctrl1 <= 16'h0000;
            r_q.vol   <= 16'hFFFF;
            r_q.ctrl2 <= 16'h4410;
            r_q.pwr   <= 16'h8540;
            r_q.ctrl3 <= 16'h0000;
            r_q.pll1  <= 16'h1004;
            r_q.pll2  <= 16'h0000;
            r_q.ss_en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    settle_timer #(.PRESCALE(TICK_DIV), .LIMIT(SETTLE_TICKS)) u_vol_tmr (
        .clk(clk), .rst_n(rst_n), .restart(vol_start), .done(vol_done));

    settle_timer #(.PRESCALE(TICK_DIV), .LIMIT(SETTLE_TICKS)) u_pd_tmr (
        .clk(clk), .rst_n(rst_n), .restart(pd_start), .done(pd_done));

    coef_bank #(.NCH(COEF_CH), .PER(COEF_PER_CH), .AW(AW)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(wr_en && in_coef), .idx(coef_idx),
        .wdata(wdata), .rdata(coef_rd));

    rate_decode u_rate (
        .divisor(r_q.ctrl1[5:0]), .ref44(r_q.ctrl3[13]),
        .rate_hz(rate_hz), .rate_bad(rate_bad));

    assign dac_en    = !r_q.pwr[15] && !r_q.pwr[10];
    assign ramp_done = (r_q.ss_en && !r_q.pwr[10]) ? vol_done : 1'b1;
    assign c3_flags  = r_q.ctrl3[7:6];
    assign pwr_b10   = r_q.pwr[10];

    always_comb begin
        case (addr)
            AW'(OFF_CTRL1): rdata = r_q.ctrl1;
            AW'(OFF_FIX1):  rdata = 16'hFF00;
            AW'(OFF_VOL):   rdata = r_q.vol;
            AW'(OFF_FIX3):  rdata = 16'h8B00;
            AW'(OFF_CTRL2): rdata = r_q.ctrl2 | {12'h000, ramp_done, ramp_done, 2'b00};
            AW'(OFF_PWR):   rdata = OR_PWR | r_q.pwr |
                                    {9'h000, r_q.pwr[10] && pd_done, 6'h00};
            AW'(OFF_CTRL3): rdata = r_q.ctrl3 | 16'h0001;
            AW'(OFF_PLL1):  rdata = r_q.pll1;
            AW'(OFF_PLL2):  rdata = r_q.pll2;
            AW'(OFF_CTRL4): rdata = {1'b0, !r_q.ss_en, 14'h0000};
            default:        rdata = in_coef ? coef_rd : 16'hFFFF;
        endcase
    end
endmodule

// File: rtl/dac_ctl_regs_chk.sv
module dac_ctl_regs_chk import dacreg_pkg::*; #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [15:0]   wdata,
    input logic [1:0]    flag_evt,
    input logic [15:0]   rdata,
    input logic [16:0]   rate_hz,
    input logic          rate_bad,
    input logic          dac_en,
    input logic          vol_done,
    input logic          pd_done,
    input logic [1:0]    c3_flags,
    input logic          pwr_b10
);
    // R2
    bad_rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_bad |-> rate_hz == 17'd0);

    // R3
    dac_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFF_PWR) && wdata[15]) |=> !dac_en);

    // R5
    pd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFF_PWR) && wdata[10] && !pwr_b10) |=> !pd_done);

    // R6
    vol_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFF_VOL)) |=> !vol_done);

    // R6
    vol_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFF_VOL)) |=>
            (addr != AW'(OFF_VOL) || rdata == $past(wdata)));

    // R9
    c3_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(OFF_CTRL3) && flag_evt == 2'b00) |=> c3_flags == 2'b00);

    // R10
    fixed_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(OFF_FIX1)) |-> rdata == 16'hFF00);
endmodule

bind dac_ctl_regs dac_ctl_regs_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .flag_evt(flag_evt), .rdata(rdata), .rate_hz(rate_hz),
    .rate_bad(rate_bad), .dac_en(dac_en), .vol_done(vol_done),
    .pd_done(pd_done), .c3_flags(c3_flags), .pwr_b10(pwr_b10));

// File: tb/dac_ctl_regs_test.sv
module dac_ctl_regs_test;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [1:0]    flag_evt = 2'b00;
    logic [15:0]   rdata;
    logic [16:0]   rate_hz;
    logic          rate_bad;
    logic          dac_en;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dac_ctl_regs #(.TICK_DIV(2), .SETTLE_TICKS(6), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .flag_evt(flag_evt), .rdata(rdata), .rate_hz(rate_hz),
        .rate_bad(rate_bad), .dac_en(dac_en));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, output logic [15:0] d);
        addr = AW'(a);
        #1 d = rdata;
    endtask

    task automatic rd_strobe(int a, output logic [15:0] d);
        @(negedge clk);
        addr = AW'(a); rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] coef_exp(int k);
        case (k % 10)
            0, 3:    return 16'h6BE3;
            1, 4:    return 16'h9666;
            2, 5:    return 16'h675D;
            6, 8:    return 16'h7D83;
            default: return 16'h84EE;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset values
        rd(0, v);  check("R11 ctrl1", v, 16'h0000);
        rd(2, v);  check("R11 volume", v, 16'hFFFF);
        rd(4, v);  check("R11 ctrl2", v, 16'h441C);
        rd(5, v);  check("R11 power", v, 16'hAFE0);
        rd(6, v);  check("R11 ctrl3", v, 16'h0001);
        rd(27, v); check("R11 pll1", v, 16'h1004);
        rd(28, v); check("R11 pll2", v, 16'h0000);
        rd(29, v); check("R11 ctrl4", v, 16'h0000);
        check("R3 dac off at reset", dac_en, 0);

        // R12 coefficient reset pattern and full-width storage
        for (int i = 0; i < 20; i++) begin
            rd(7 + i, v); check("R12 coef reset", v, coef_exp(i));
        end
        for (int i = 0; i < 20; i++) wr(7 + i, 16'(16'hA5C3 ^ (i * 16'h0913)));
        for (int i = 0; i < 20; i++) begin
            rd(7 + i, v); check("R12 coef rw", v, 16'(16'hA5C3 ^ (i * 16'h0913)));
        end

        // R1, R7, R10 masks and constants
        wr(0, 16'hFFFF);  rd(0, v);  check("R1 ctrl1 mask", v, 16'h0F3F);
        wr(27, 16'hFFFF); rd(27, v); check("R10 pll1 mask", v, 16'hFFFC);
        wr(28, 16'h1237); rd(28, v); check("R10 pll2 mask", v, 16'h1234);
        rd(1, v); check("R10 fixed 1", v, 16'hFF00);
        rd(3, v); check("R10 fixed 3", v, 16'h8B00);
        wr(31, 16'h0000); wr(30, 16'h0000);
        rd(31, v); check("R10 unmapped", v, 16'hFFFF);
        rd(30, v); check("R10 unmapped", v, 16'hFFFF);
        rd(0, v);  check("R10 unmapped write ignored", v, 16'h0F3F);

        // R4, R3 power word
        wr(5, 16'hFFFF); rd(5, v); check("R4 power mask", v, 16'hBFE3);
        check("R3 dac off", dac_en, 0);
        wr(5, 16'h0000); rd(5, v); check("R4 power or", v, 16'h2AA0);
        check("R3 dac on", dac_en, 1);
        wr(5, 16'h8000); check("R3 bit15 off", dac_en, 0);
        wr(5, 16'h0000);

        // R6 soft-step, R7 ctrl2 mask
        wr(2, 16'h1234);
        rd(2, v); check("R6 volume", v, 16'h1234);
        rd(4, v); check("R6 ramp pending", v, 16'h4410);
        idle(20);
        rd(4, v); check("R6 ramp done", v, 16'h441C);
        wr(29, 16'h4000);
        rd(29, v); check("R8 ctrl4", v, 16'h4000);
        wr(2, 16'h0055);
        rd(4, v); check("R6 soft-step off", v, 16'h441C);
        wr(4, 16'hFFFF);
        rd(4, v); check("R7 ctrl2 mask", v, 16'hF7FE);
        wr(29, 16'h0000);
        rd(29, v); check("R8 ctrl4 enabled", v, 16'h0000);
        wr(2, 16'h0066);
        rd(4, v); check("R6 ramp restarted", v, 16'hF7F2);

        // R5 power-down completion
        wr(5, 16'h0400);
        rd(5, v); check("R5 pd pending", v, 16'h2EA0);
        rd(4, v); check("R6 bit10 forces done", v, 16'hF7FE);
        idle(20);
        rd(5, v); check("R5 pd done", v, 16'h2EE0);
        wr(5, 16'h0000);
        rd(5, v); check("R5 bit10 clear", v, 16'h2AA0);

        // R9 control 3
        @(negedge clk); flag_evt = 2'b11; @(negedge clk); flag_evt = 2'b00;
        wr(6, 16'hFFFF);
        rd(6, v); check("R9 ctrl3 write", v, 16'hF8C1);
        rd(6, v); check("R9 plain read keeps", v, 16'hF8C1);
        rd_strobe(6, v); check("R9 strobe read value", v, 16'hF8C1);
        rd(6, v); check("R9 cleared", v, 16'hF801);
        @(negedge clk); flag_evt = 2'b01; @(negedge clk); flag_evt = 2'b00;
        rd(6, v); check("R9 event bit6", v, 16'hF841);
        @(negedge clk); addr = AW'(6); rd_en = 1'b1; flag_evt = 2'b10;
        @(negedge clk); rd_en = 1'b0; flag_evt = 2'b00;
        rd(6, v); check("R9 event beats clear", v, 16'hF881);

        // R2 rate sweep over all codes and both references
        for (int r = 0; r < 2; r++) begin
            wr(6, r[0] ? 16'h2000 : 16'h0000);
            for (int c = 0; c < 64; c++) begin
                int n2;
                logic [16:0] exp_hz;
                wr(0, 16'(c));
                case (c / 9)
                    0: n2 = 2;  1: n2 = 3;  2: n2 = 4;  3: n2 = 6;
                    4: n2 = 8;  5: n2 = 10; default: n2 = 12;
                endcase
                exp_hz = (c % 9 == 0) ? 17'((r[0] ? 88200 : 96000) / n2) : 17'd0;
                #1;
                check("R2 rate", rate_hz, exp_hz);
                check("R2 bad flag", rate_bad, (c % 9 != 0));
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule